// File: doc/BRIEF.md
# In-Order Four-Stage Pipeline Hazard Timing Model

This block is a cycle-accurate occupancy model of a single-issue, in-order pipeline with four stages: fetch, decode, issue and execute. It takes a stream of instruction descriptors. Each descriptor carries a tag, an optional destination register, up to two optional source registers and an optional memory access (address plus a write flag). The block does not compute results. It tracks where each instruction is in every cycle and stalls the front of the pipeline on read-after-write dependences.

A per-register scoreboard marks registers that an older in-flight instruction has yet to write. When the instruction in decode reads such a register, decode holds it and fetch accepts nothing. The producer keeps moving, which leaves an issue bubble. The held instruction enters issue in the cycle after its producer has executed. In that same cycle fetch accepts the next descriptor, so decode is empty for one cycle.

Every cycle the block reports the tag and valid bit of each stage and a stall flag. It also keeps a free-running cycle count and a retired-instruction count, so that the caller can compute instructions per clock. A drain input closes the input stream and raises a done flag once the pipeline is empty.

Top module: `pipe_timing_model`

## Requirements
- R1: Instructions pass through fetch, decode, issue and execute in that order, at most one enters fetch per edge, and each spends exactly one cycle in execute. An independent stream fetched in cycles 1, 2, 3, ... executes in cycles 4, 5, 6, ... with no stall.
- R2: The stall flag is high exactly when decode holds a valid instruction that has an enabled source equal to the enabled destination of a valid instruction in issue or execute. A source or destination whose enable bit is 0 never causes a stall.
- R3: In every cycle the stall flag is high, the fetch slot is empty. Input ready is low before any edge that leads into a stalled cycle.
- R4: While the producer of a held instruction sits in issue, the consumer stays in decode and the issue slot is empty in the next cycle.
- R5: A held consumer enters issue in the cycle right after its producer's execute cycle.
- R6: Fetch accepts a new descriptor at the same edge where the held instruction leaves decode, so decode is empty in the following cycle.
- R7: For the sequence (write r3), (read r3), (read r3 with a memory read), fed from cycle 1: the second instruction is in decode in cycles 3 and 4 and in issue in cycle 5. Fetch is empty in cycles 3 and 4, the third instruction is fetched in cycle 5, and it executes in cycle 8.
- R8: The memory enable, write flag and address of a descriptor appear unchanged on the execute outputs in its execute cycle. They never change timing.
- R9: Register 0 is an ordinary register for dependence tracking.
- R10: The cycle counter is 0 at reset release and equals k during the k-th cycle after it.
- R11: The retired counter increases by one at the edge that ends each cycle in which execute is valid.
- R12: While drain is high, input ready is low and nothing is fetched. Done is high exactly when drain is high and all four stages are empty.
- R13: After reset all stage slots are empty, both counters are zero, stall and done are low, and ready is high while drain is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Descriptor offered |
| inReady | output | 1 | Descriptor accepted at this edge if valid |
| inTag | input | TagW | Instruction tag |
| inDst | input | RegW | Destination register |
| inDstEn | input | 1 | Destination used |
| inSrcA | input | RegW | First source register |
| inSrcAEn | input | 1 | First source used |
| inSrcB | input | RegW | Second source register |
| inSrcBEn | input | 1 | Second source used |
| inMemEn | input | 1 | Descriptor has a memory access |
| inMemWrite | input | 1 | Memory access is a write |
| inMemAddr | input | AddrW | Memory address |
| drain | input | 1 | Close the input and let the pipeline empty |
| fetchValid | output | 1 | Fetch slot occupied |
| fetchTag | output | TagW | Fetch slot tag |
| decodeValid | output | 1 | Decode slot occupied |
| decodeTag | output | TagW | Decode slot tag |
| issueValid | output | 1 | Issue slot occupied |
| issueTag | output | TagW | Issue slot tag |
| execValid | output | 1 | Execute slot occupied |
| execTag | output | TagW | Execute slot tag |
| execMemEn | output | 1 | Memory enable of executing instruction |
| execMemWrite | output | 1 | Write flag of executing instruction |
| execMemAddr | output | AddrW | Address of executing instruction |
| stallFlag | output | 1 | Decode stalled on a dependence this cycle |
| cycleCount | output | CntW | Cycles since reset |
| retireCount | output | CntW | Instructions that completed execute |
| done | output | 1 | Drain requested and pipeline empty |

## Verification
On every cycle the assertions check four things. The stall flag must match a direct comparison of decode's sources against the issue and execute destinations. Decode must hold whenever the producer sits in issue. Fetch must be empty during a stall, and decode must be empty right after a stall clears. Done must imply an empty pipeline and a closed input. The bench scenarios cover the rest: the exact cycle in which each tag reaches each stage for a dependent pair, a producer two slots ahead, register 0, disabled sources and an independent stream. They also cover the pass-through of memory fields, the values of both counters and the drain sequence.

// File: rtl/pipe_model_pkg.sv
package pipe_model_pkg;
  parameter int TagW  = 8;
  parameter int RegW  = 5;
  parameter int AddrW = 32;
  localparam int NReg = 1 << RegW;

  typedef struct packed {
    logic             valid;
    logic [TagW-1:0]  tag;
    logic [RegW-1:0]  dst;
    logic             dstEn;
    logic [RegW-1:0]  srcA;
    logic             srcAEn;
    logic [RegW-1:0]  srcB;
    logic             srcBEn;
    logic             memEn;
    logic             memWrite;
    logic [AddrW-1:0] memAddr;
  } slot_t;

  typedef struct packed {
    logic advDecode;
    logic takeInput;
    logic stall;
  } strobe_t;
endpackage

// File: rtl/hazard_ctrl.sv
module hazard_ctrl import pipe_model_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  slot_t   fetchSlot,
  input  slot_t   decSlot,
  input  slot_t   issSlot,
  input  slot_t   exeSlot,
  input  logic    inValid,
  input  logic    drain,
  output strobe_t strobe,
  output logic    inReady
);
  logic [NReg-1:0] pending, clrMask, live, setMask, pendingNext;
  logic  hold, nextStall;
  slot_t nextDec;

  function automatic logic readsAny(slot_t s, logic [NReg-1:0] m);
    return s.valid && ((s.srcAEn && m[s.srcA]) || (s.srcBEn && m[s.srcB]));
  endfunction

  always_comb begin
    clrMask = '0;
    if (exeSlot.valid && exeSlot.dstEn &&
        !(issSlot.valid && issSlot.dstEn && issSlot.dst == exeSlot.dst))
      clrMask[exeSlot.dst] = 1'b1;
    live = pending & ~clrMask;
    hold = readsAny(decSlot, live);
    setMask = '0;
    if (!hold && decSlot.valid && decSlot.dstEn)
      setMask[decSlot.dst] = 1'b1;
    pendingNext = live | setMask;
    nextDec   = hold ? decSlot : fetchSlot;
    nextStall = readsAny(nextDec, pendingNext);
    inReady   = !nextStall && !drain;
    strobe.advDecode = !hold;
    strobe.takeInput = inReady && inValid;
    strobe.stall     = readsAny(decSlot, pending);
  end

  always_ff @(posedge clk) begin
    if (!rstN) pending <= '0;
    else       pending <= pendingNext;
  end

  // Independent slot comparison for the checks below
  function automatic logic srcHit(slot_t c, slot_t p);
    return c.valid && p.valid && p.dstEn &&
           ((c.srcAEn && c.srcA == p.dst) || (c.srcBEn && c.srcB == p.dst));
  endfunction

  logic issHit, exeHit;
  assign issHit = srcHit(decSlot, issSlot);
  assign exeHit = srcHit(decSlot, exeSlot);

  a_r2_stall_matches_producers: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stall == (issHit || exeHit));
  a_r4_hold_behind_issue: assert property (@(posedge clk) disable iff (!rstN)
    issHit |-> !strobe.advDecode);
endmodule

// File: rtl/pipe_stages.sv
module pipe_stages import pipe_model_pkg::*; #(
  parameter int CntW = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strobe,
  input  slot_t           inSlot,
  output slot_t           fetchSlot,
  output slot_t           decSlot,
  output slot_t           issSlot,
  output slot_t           exeSlot,
  output logic [CntW-1:0] cycleCount,
  output logic [CntW-1:0] retireCount
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchSlot   <= '0;
      decSlot     <= '0;
      issSlot     <= '0;
      exeSlot     <= '0;
      cycleCount  <= '0;
      retireCount <= '0;
    end else begin
      if (strobe.takeInput)      fetchSlot <= inSlot;
      else if (strobe.advDecode) fetchSlot <= '0;
      if (strobe.advDecode) begin
        decSlot <= fetchSlot;
        issSlot <= decSlot;
      end else begin
        issSlot <= '0;
      end
      exeSlot    <= issSlot;
      cycleCount <= cycleCount + 1'b1;
      if (exeSlot.valid) retireCount <= retireCount + 1'b1;
    end
  end

  a_r3_fetch_empty_in_stall: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stall |-> !fetchSlot.valid);
  a_r6_decode_bubble_after_release: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stall && strobe.advDecode) |=> !decSlot.valid);
endmodule

// File: rtl/pipe_timing_model.sv
module pipe_timing_model import pipe_model_pkg::*; #(
  parameter int CntW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [TagW-1:0]  inTag,
  input  logic [RegW-1:0]  inDst,
  input  logic             inDstEn,
  input  logic [RegW-1:0]  inSrcA,
  input  logic             inSrcAEn,
  input  logic [RegW-1:0]  inSrcB,
  input  logic             inSrcBEn,
  input  logic             inMemEn,
  input  logic             inMemWrite,
  input  logic [AddrW-1:0] inMemAddr,
  input  logic             drain,
  output logic             fetchValid,
  output logic [TagW-1:0]  fetchTag,
  output logic             decodeValid,
  output logic [TagW-1:0]  decodeTag,
  output logic             issueValid,
  output logic [TagW-1:0]  issueTag,
  output logic             execValid,
  output logic [TagW-1:0]  execTag,
  output logic             execMemEn,
  output logic             execMemWrite,
  output logic [AddrW-1:0] execMemAddr,
  output logic             stallFlag,
  output logic [CntW-1:0]  cycleCount,
  output logic [CntW-1:0]  retireCount,
  output logic             done
);
  slot_t   inSlot, fetchSlot, decSlot, issSlot, exeSlot;
  strobe_t strobe;

  always_comb begin
    inSlot          = '0;
    inSlot.valid    = inValid;
    inSlot.tag      = inTag;
    inSlot.dst      = inDst;
    inSlot.dstEn    = inDstEn;
    inSlot.srcA     = inSrcA;
    inSlot.srcAEn   = inSrcAEn;
    inSlot.srcB     = inSrcB;
    inSlot.srcBEn   = inSrcBEn;
    inSlot.memEn    = inMemEn;
    inSlot.memWrite = inMemWrite;
    inSlot.memAddr  = inMemAddr;
  end

  hazard_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .fetchSlot(fetchSlot), .decSlot(decSlot),
    .issSlot(issSlot), .exeSlot(exeSlot), .inValid(inValid), .drain(drain),
    .strobe(strobe), .inReady(inReady)
  );

  pipe_stages #(.CntW(CntW)) uStages (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inSlot(inSlot),
    .fetchSlot(fetchSlot), .decSlot(decSlot), .issSlot(issSlot), .exeSlot(exeSlot),
    .cycleCount(cycleCount), .retireCount(retireCount)
  );

  assign fetchValid   = fetchSlot.valid;
  assign fetchTag     = fetchSlot.tag;
  assign decodeValid  = decSlot.valid;
  assign decodeTag    = decSlot.tag;
  assign issueValid   = issSlot.valid;
  assign issueTag     = issSlot.tag;
  assign execValid    = exeSlot.valid;
  assign execTag      = exeSlot.tag;
  assign execMemEn    = exeSlot.memEn;
  assign execMemWrite = exeSlot.memWrite;
  assign execMemAddr  = exeSlot.memAddr;
  assign stallFlag    = strobe.stall;
  assign done = drain && !(fetchSlot.valid || decSlot.valid || issSlot.valid || exeSlot.valid);

  a_r12_done_means_empty: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!fetchValid && !decodeValid && !issueValid && !execValid && !inReady));
endmodule

// File: tb/sim_pipe_timing_model.sv
`timescale 1ns/1ps
module sim_pipe_timing_model;
  import pipe_model_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, drain = 1'b0;
  logic [TagW-1:0] inTag = '0;
  logic [RegW-1:0] inDst = '0, inSrcA = '0, inSrcB = '0;
  logic inDstEn = 1'b0, inSrcAEn = 1'b0, inSrcBEn = 1'b0, inMemEn = 1'b0, inMemWrite = 1'b0;
  logic [AddrW-1:0] inMemAddr = '0;
  logic inReady, fetchValid, decodeValid, issueValid, execValid;
  logic [TagW-1:0] fetchTag, decodeTag, issueTag, execTag;
  logic execMemEn, execMemWrite, stallFlag, done;
  logic [AddrW-1:0] execMemAddr;
  logic [31:0] cycleCount, retireCount;

  always #4 clk = ~clk;

  pipe_timing_model u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inTag(inTag),
    .inDst(inDst), .inDstEn(inDstEn), .inSrcA(inSrcA), .inSrcAEn(inSrcAEn),
    .inSrcB(inSrcB), .inSrcBEn(inSrcBEn), .inMemEn(inMemEn), .inMemWrite(inMemWrite),
    .inMemAddr(inMemAddr), .drain(drain), .fetchValid(fetchValid), .fetchTag(fetchTag),
    .decodeValid(decodeValid), .decodeTag(decodeTag), .issueValid(issueValid),
    .issueTag(issueTag), .execValid(execValid), .execTag(execTag),
    .execMemEn(execMemEn), .execMemWrite(execMemWrite), .execMemAddr(execMemAddr),
    .stallFlag(stallFlag), .cycleCount(cycleCount), .retireCount(retireCount), .done(done)
  );

  int total = 0, bad = 0;
  slot_t seq [0:7];
  int rF[0:15], rD[0:15], rI[0:15], rE[0:15];
  int rStall[0:15], rRdy[0:15], rCyc[0:15], rRet[0:15], rDone[0:15];
  int rMemEn[0:15], rMemW[0:15];
  logic [AddrW-1:0] rAddr[0:15];

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic slot_t mk(input int tag, input int dst, input bit dEn, input int a,
                               input bit aEn, input int b, input bit bEn,
                               input bit mEn, input bit mW, input logic [AddrW-1:0] addr);
    slot_t s;
    s.valid = 1'b1; s.tag = TagW'(tag);
    s.dst = RegW'(dst); s.dstEn = dEn;
    s.srcA = RegW'(a); s.srcAEn = aEn;
    s.srcB = RegW'(b); s.srcBEn = bEn;
    s.memEn = mEn; s.memWrite = mW; s.memAddr = addr;
    return s;
  endfunction

  task automatic doReset();
    rstN = 1'b0; inValid = 1'b0; drain = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  task automatic record(input int k);
    rF[k] = fetchValid ? int'(fetchTag) : -1;
    rD[k] = decodeValid ? int'(decodeTag) : -1;
    rI[k] = issueValid ? int'(issueTag) : -1;
    rE[k] = execValid ? int'(execTag) : -1;
    rStall[k] = int'(stallFlag);
    rCyc[k] = int'(cycleCount);
    rRet[k] = int'(retireCount);
    rDone[k] = int'(done);
    rMemEn[k] = int'(execMemEn);
    rMemW[k] = int'(execMemWrite);
    rAddr[k] = execMemAddr;
  endtask

  // Cycle k is the state after the k-th edge since the run started.
  task automatic run(input int n, input int m, input int drainFrom);
    int idx = 0;
    bit acc;
    for (int k = 1; k <= m; k++) begin
      slot_t s;
      s = (idx < n) ? seq[idx] : '0;
      inValid = (idx < n);
      inTag = s.tag; inDst = s.dst; inDstEn = s.dstEn;
      inSrcA = s.srcA; inSrcAEn = s.srcAEn; inSrcB = s.srcB; inSrcBEn = s.srcBEn;
      inMemEn = s.memEn; inMemWrite = s.memWrite; inMemAddr = s.memAddr;
      drain = (k >= drainFrom);
      #1;
      rRdy[k] = int'(inReady);
      acc = inValid && inReady;
      @(posedge clk);
      if (acc) idx++;
      @(negedge clk);
      record(k);
    end
    inValid = 1'b0; drain = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    chk("R13 fetch empty", int'(fetchValid), 0);
    chk("R13 decode empty", int'(decodeValid), 0);
    chk("R13 issue empty", int'(issueValid), 0);
    chk("R13 exec empty", int'(execValid), 0);
    chk("R13 cycle zero", int'(cycleCount), 0);
    chk("R13 retire zero", int'(retireCount), 0);
    chk("R13 stall low", int'(stallFlag), 0);
    chk("R13 done low", int'(done), 0);
    chk("R13 ready high", int'(inReady), 1);
  endtask

  task automatic testExample();
    int eF[1:8] = '{1, 2, -1, -1, 3, -1, -1, -1};
    int eD[1:8] = '{-1, 1, 2, 2, -1, 3, -1, -1};
    int eI[1:8] = '{-1, -1, 1, -1, 2, -1, 3, -1};
    int eE[1:8] = '{-1, -1, -1, 1, -1, 2, -1, 3};
    doReset();
    seq[0] = mk(1, 3, 1, 4, 1, 0, 0, 0, 0, '0);
    seq[1] = mk(2, 0, 0, 3, 1, 0, 0, 0, 0, '0);
    seq[2] = mk(3, 1, 1, 3, 1, 0, 0, 1, 0, 32'h1234_5678);
    run(3, 9, 100);
    for (int k = 1; k <= 8; k++) begin
      chk("R7 fetch slot", rF[k], eF[k]);
      chk("R7 decode slot", rD[k], eD[k]);
      chk("R4 R5 issue slot", rI[k], eI[k]);
      chk("R1 exec slot", rE[k], eE[k]);
      chk("R2 R3 stall flag", rStall[k], (k == 3 || k == 4) ? 1 : 0);
      chk("R10 cycle count", rCyc[k], k);
    end
    chk("R3 ready low before stalled cycle 3", rRdy[3], 0);
    chk("R3 ready low before stalled cycle 4", rRdy[4], 0);
    chk("R6 fetch resumes with decode bubble", rF[5] == 3 && rD[5] == -1 ? 1 : 0, 1);
    chk("R11 retire count before last exec", rRet[8], 2);
    chk("R11 retire count final", rRet[9], 3);
    chk("R8 mem enable at exec", rMemEn[8], 1);
    chk("R8 mem write flag at exec", rMemW[8], 0);
    chk("R8 mem address at exec", int'(rAddr[8] == 32'h1234_5678), 1);
  endtask

  task automatic testIndependent();
    doReset();
    for (int i = 0; i < 4; i++)
      seq[i] = mk(10 + i, 10 + i, 1, 20 + i, 1, 10 + i, 1, 1, i[0], 32'h100 * (i + 1));
    run(4, 8, 100);
    for (int i = 0; i < 4; i++) begin
      chk("R1 fetched one per cycle", rF[1 + i], 10 + i);
      chk("R1 exec three cycles after fetch", rE[4 + i], 10 + i);
      chk("R8 write flag passes", rMemW[4 + i], i % 2);
      chk("R8 address passes", int'(rAddr[4 + i] == 32'h100 * (i + 1)), 1);
    end
    for (int k = 1; k <= 8; k++) chk("R8 no stall from memory fields", rStall[k], 0);
    chk("R11 retire after stream", rRet[8], 4);
  endtask

  task automatic testRegZero();
    doReset();
    seq[0] = mk(20, 0, 1, 5, 1, 0, 0, 0, 0, '0);
    seq[1] = mk(21, 6, 1, 0, 1, 0, 0, 0, 0, '0);
    run(2, 7, 100);
    chk("R9 r0 dependence stalls", rStall[3], 1);
    chk("R9 consumer held", rD[4], 21);
    chk("R9 consumer exec cycle", rE[6], 21);
  endtask

  task automatic testDisabledSrc();
    doReset();
    seq[0] = mk(30, 3, 1, 1, 1, 0, 0, 0, 0, '0);
    seq[1] = mk(31, 4, 1, 3, 0, 3, 0, 0, 0, '0);
    run(2, 6, 100);
    chk("R2 disabled sources no stall", rStall[3], 0);
    chk("R2 disabled sources exec cycle", rE[5], 31);
  endtask

  task automatic testFarProducer();
    int eF[1:8] = '{40, 41, 42, -1, 43, -1, -1, -1};
    int eD[1:8] = '{-1, 40, 41, 42, -1, 43, -1, -1};
    int eE[1:8] = '{-1, -1, -1, 40, 41, 42, -1, 43};
    doReset();
    seq[0] = mk(40, 7, 1, 2, 1, 0, 0, 0, 0, '0);
    seq[1] = mk(41, 8, 1, 1, 1, 0, 0, 0, 0, '0);
    seq[2] = mk(42, 9, 1, 7, 1, 0, 0, 0, 0, '0);
    seq[3] = mk(43, 11, 1, 12, 1, 0, 0, 0, 0, '0);
    run(4, 8, 100);
    for (int k = 1; k <= 8; k++) begin
      chk("R6 fetch slot far producer", rF[k], eF[k]);
      chk("R6 decode slot far producer", rD[k], eD[k]);
      chk("R5 exec slot far producer", rE[k], eE[k]);
      chk("R2 stall only with producer in exec", rStall[k], (k == 4) ? 1 : 0);
    end
    chk("R5 consumer issues after producer exec", rI[5], 42);
  endtask

  task automatic testDrain();
    doReset();
    seq[0] = mk(50, 1, 1, 2, 1, 0, 0, 0, 0, '0);
    seq[1] = mk(51, 3, 1, 4, 1, 0, 0, 0, 0, '0);
    seq[2] = mk(52, 5, 1, 6, 1, 0, 0, 0, 0, '0);
    run(3, 7, 3);
    chk("R12 ready low while draining", rRdy[3], 0);
    for (int k = 3; k <= 6; k++) chk("R12 nothing fetched", rF[k], -1);
    chk("R12 done low while busy", rDone[5], 0);
    chk("R12 done when empty", rDone[6], 1);
    chk("R12 retire after drain", rRet[6], 2);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testExample();
    testIndependent();
    testRegZero();
    testDisabledSrc();
    testFarProducer();
    testDrain();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule